// File: doc/BRIEF.md
# Run-Length Expanding Receive FIFO

This block sits on the receive side of an extended-capability parallel port, between the port engine and the host-side reader. The engine delivers a stream of bytes. Each byte carries a flag that marks it as data or as command. A command byte whose bit 7 is clear is a run-length count. The block consumes that byte and does not store it. The next data byte is then written into a 16-entry FIFO once for the byte itself plus once for each unit of the count.

While the block expands a run, it holds the input stalled. It writes one copy per clock whenever the FIFO has room. A command byte with bit 7 set is a channel address. It goes out on a separate address output and never reaches the FIFO.

The host drains the FIFO through a valid/ready pair and can also see the full and empty flags. A decode-enable input selects between expansion and a bypass mode. In bypass, data bytes pass through one for one and run-length commands are discarded. A synchronous clear empties the FIFO and forgets any count that is still waiting.

Top module: `rle_rx_fifo`

## Requirements
- R1: After reset the FIFO is empty: `empty`=1, `full`=0, `out_valid`=0 and `in_ready`=1.
- R2: The FIFO holds exactly 16 bytes. After 16 writes with no reads, `full`=1 and `in_ready`=0.
- R3: Data bytes (`in_cmd`=0) with no pending count are written once each and read back in arrival order.
- R4: With decoding on, a command byte whose bit 7 is 0 carries a count N in bits 6:0. The next data byte is then written N+1 times (1 to 128 copies). The command byte itself is never stored.
- R5: From the clock edge that accepts a data byte to be expanded until its last copy is written, `in_ready` is 0. One copy is written on each clock in which the FIFO is not full. A stalled expansion resumes after the host reads.
- R6: When two run-length commands arrive back to back, the count of the second one is used and the first is discarded.
- R7: A command byte whose bit 7 is 1 raises `addr_valid` for one cycle, in the cycle after it is accepted, with `addr_data` equal to its bits 6:0. It is not stored and does not arm expansion.
- R8: With `dec_en`=0, every data byte is written exactly once and run-length command bytes are dropped.
- R9: A `clr` pulse empties the FIFO in the next cycle and discards any pending count. The data byte that follows is then written only once.
- R10: A byte is removed when `out_valid` and `out_ready` are both 1. `out_valid` always equals the inverse of `empty`, and `full` and `empty` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous FIFO and count clear |
| dec_en | input | 1 | 1 = expand run-length commands, 0 = bypass |
| in_valid | input | 1 | Input byte present |
| in_cmd | input | 1 | 1 = command byte, 0 = data byte |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted this cycle when high with in_valid |
| addr_valid | output | 1 | One-cycle pulse for a received channel address |
| addr_data | output | 7 | Channel address value |
| out_valid | output | 1 | FIFO holds at least one byte |
| out_ready | input | 1 | Host takes the head byte |
| out_data | output | 8 | Head byte of the FIFO |
| full | output | 1 | FIFO holds 16 bytes |
| empty | output | 1 | FIFO holds no bytes |

## Verification
The assertions check several properties on every clock:
- the fill level never exceeds the depth and the flags stay consistent;
- `full` always blocks the input;
- an accepted command byte leaves the fill level unchanged;
- an address pulse always follows an accepted address byte;
- a clear always leaves the FIFO empty.

Some behaviour depends on values and counts, and only the directed scenarios can show it:
- the number of copies an expansion produces;
- which count wins when two arrive in a row;
- the exact span of cycles during which input is stalled;
- resumption after a full stall;
- one-for-one pass-through in bypass.

// File: rtl/rle_rx_fifo.sv
module rle_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           dec_en,
  input  logic           in_valid,
  input  logic           in_cmd,
  input  logic [W-1:0]   in_data,
  output logic           in_ready,
  output logic           addr_valid,
  output logic [W-2:0]   addr_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_data,
  output logic           full,
  output logic           empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = W - 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fill;
  logic          armed;
  logic [CW-1:0] cnt_q, left;
  logic [W-1:0]  hold;

  logic busy, acc, is_rle, is_addr, wr_en, rd_en, expand;
  logic [W-1:0] wr_data;

  assign busy      = left != '0;
  assign full      = fill == (AW+1)'(DEPTH);
  assign empty     = fill == '0;
  assign in_ready  = !busy && !full;
  assign acc       = in_valid && in_ready;
  assign is_rle    = in_cmd && !in_data[W-1];
  assign is_addr   = in_cmd && in_data[W-1];
  assign expand    = acc && !in_cmd && armed && dec_en;
  assign wr_en     = busy ? !full : (acc && !in_cmd);
  assign wr_data   = busy ? hold : in_data;
  assign out_valid = !empty;
  assign rd_en     = out_valid && out_ready;
  assign out_data  = mem[rp];

  always_ff @(posedge clk)
    if (wr_en) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (wr_en) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      armed <= 1'b0;
      cnt_q <= '0;
      left  <= '0;
      hold  <= '0;
    end else begin
      if (acc && is_rle && dec_en) begin
        armed <= 1'b1;
        cnt_q <= in_data[CW-1:0];
      end else if (expand) begin
        armed <= 1'b0;
        left  <= cnt_q;
        hold  <= in_data;
      end else if (busy && !full) begin
        left  <= left - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      addr_valid <= 1'b0;
      addr_data  <= '0;
    end else begin
      addr_valid <= acc && is_addr;
      if (acc && is_addr) addr_data <= in_data[CW-1:0];
    end
  end
endmodule

// File: rtl/rle_rx_fifo_chk.sv
module rle_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int FW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_cmd,
  input logic          in_msb,
  input logic          out_valid,
  input logic          out_ready,
  input logic          full,
  input logic          empty,
  input logic          addr_valid,
  input logic [FW-1:0] fill
);
  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  // R2
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);

  // R10
  flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty) && (out_valid == !empty));

  // R4
  cmd_unstored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_cmd && !clr && !(out_valid && out_ready))
      |=> fill == $past(fill));

  // R7
  addr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $past(in_valid && in_ready && in_cmd && in_msb));

  // R9
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

bind rle_rx_fifo rle_rx_fifo_chk #(.DEPTH(DEPTH), .FW($clog2(DEPTH)+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
  .in_ready(in_ready), .in_cmd(in_cmd), .in_msb(in_data[W-1]),
  .out_valid(out_valid), .out_ready(out_ready), .full(full),
  .empty(empty), .addr_valid(addr_valid), .fill(fill)
);

// File: tb/sim_rle_rx_fifo.sv
module sim_rle_rx_fifo;
  logic clk = 0, rst_n = 0, clr = 0, dec_en = 1;
  logic in_valid = 0, in_cmd = 0, out_ready = 0;
  logic [7:0] in_data = 0;
  logic in_ready, addr_valid, out_valid, full, empty;
  logic [6:0] addr_data;
  logic [7:0] out_data;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  rle_rx_fifo u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic c, input logic [7:0] d);
    in_valid = 1; in_cmd = c; in_data = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_cmd = 0;
  endtask

  task automatic pop_expect(input logic [7:0] exp, input string tag);
    int t = 0;
    while (!out_valid && t < 200) begin @(negedge clk); t++; end
    check(out_valid && out_data == exp, tag, int'(out_data), int'(exp));
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic drain(input logic [7:0] exp, input int n, input string tag);
    int got = 0, idle = 0, bad = 0;
    while (idle < 6) begin
      if (out_valid) begin
        if (out_data != exp) bad++;
        out_ready = 1; got++; idle = 0;
      end else begin
        out_ready = 0; idle++;
      end
      @(negedge clk);
    end
    out_ready = 0;
    check(got == n, {tag, " count"}, got, n);
    check(bad == 0, {tag, " value"}, bad, 0);
  endtask

  task automatic t_reset();
    check(empty && !full && !out_valid && in_ready, "R1 reset state",
          {empty, full, out_valid, in_ready}, 4'b1001);
  endtask

  task automatic t_plain();
    send(0, 8'h12); send(0, 8'h34); send(0, 8'h56);
    pop_expect(8'h12, "R3 order 0");
    pop_expect(8'h34, "R3 order 1");
    pop_expect(8'h56, "R3 order 2");
    check(empty && !out_valid, "R10 empty after pops", out_valid, 0);
  endtask

  task automatic t_rle();
    send(1, 8'h04); send(0, 8'hAB);
    drain(8'hAB, 5, "R4 expand N=4");
    send(1, 8'h00); send(0, 8'hC1);
    drain(8'hC1, 1, "R4 expand N=0");
  endtask

  task automatic t_busy();
    send(1, 8'h05); send(0, 8'h77);
    check(in_ready == 0, "R5 stall starts", in_ready, 0);
    repeat (4) @(negedge clk);
    check(in_ready == 0, "R5 stall holds", in_ready, 0);
    @(negedge clk);
    check(in_ready == 1, "R5 stall ends", in_ready, 1);
    drain(8'h77, 6, "R5 copies");
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) send(0, 8'(i));
    check(full && !in_ready, "R2 full at 16", {full, in_ready}, 2'b10);
    for (int i = 0; i < 16; i++) pop_expect(8'(i), "R2 content");
    send(1, 8'h13); send(0, 8'h5A);
    repeat (20) @(negedge clk);
    check(full && !in_ready, "R5 stalled on full", {full, in_ready}, 2'b10);
    drain(8'h5A, 20, "R5 resume after read");
  endtask

  task automatic t_replace();
    send(1, 8'h07); send(1, 8'h01); send(0, 8'h33);
    drain(8'h33, 2, "R6 second count wins");
  endtask

  task automatic t_addr();
    send(1, 8'h85);
    check(addr_valid && addr_data == 7'd5, "R7 address pulse", int'(addr_data), 5);
    @(negedge clk);
    check(!addr_valid, "R7 pulse width", addr_valid, 0);
    check(empty, "R7 address not stored", empty, 1);
    send(0, 8'h44);
    drain(8'h44, 1, "R7 no arming");
  endtask

  task automatic t_bypass();
    dec_en = 0;
    send(1, 8'h03); send(0, 8'h11); send(0, 8'h22);
    repeat (4) @(negedge clk);
    pop_expect(8'h11, "R8 bypass first");
    pop_expect(8'h22, "R8 bypass second");
    check(empty, "R8 command dropped", empty, 1);
    dec_en = 1;
  endtask

  task automatic t_clr();
    send(0, 8'h01); send(0, 8'h02); send(1, 8'h09);
    clr = 1; @(negedge clk); clr = 0;
    check(empty && !out_valid, "R9 clear empties", out_valid, 0);
    send(0, 8'h66);
    drain(8'h66, 1, "R9 count discarded");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_rle();
    t_busy();
    t_full();
    t_replace();
    t_addr();
    t_bypass();
    t_clr();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule